// File: doc/BRIEF.md
# Response Ring Dispatcher with Per-Codec Pending Counters

The dispatcher drains an inbound ring of 256 response entries that a link-side producer fills. Each entry is 64 bits: the low word is the 32-bit response payload and the high word is the 32-bit extended word. Bits 3:0 of the extended word carry the codec address, and bit 4 marks an unsolicited event. The block follows the producer's write pointer. For each new entry it advances its own read pointer by one, modulo 256, and then fetches that slot.

The block keeps an 8-bit pending-command counter and a 32-bit last-response register for every supported codec address. The command side raises a one-cycle issue pulse per codec whenever it sends a command. A solicited response for a codec with outstanding commands is stored and consumes one count. When the count reaches zero, a one-cycle completion flag fires for that codec. Unsolicited events leave through a valid/ready event stream.

The event stream obeys these back-pressure rules. While `evt_valid` is high and `evt_ready` is low, the payload holds steady. Ring consumption also stalls, so no later entry is read until the event is taken.

Two kinds of entry are dropped and flagged. A solicited entry for a codec with no pending count raises a spurious flag. An address at or above the supported codec count raises a fatal flag.

The ring read port has a fixed latency of one cycle. Data for the index presented with `ring_rd_en` must appear on `ring_rd_data` in the following cycle.

Top module: `resp_ring_dispatch`

## Requirements
- R1: After reset every pending counter is 0 (`codec_idle` all ones), `cons_rp` is 0, and `ring_rd_en`, `evt_valid`, `resp_irq`, `codec_done`, `err_spurious` and `err_fatal` are all low.
- R2: A `cmd_issue[i]` pulse adds one to codec i's pending counter. The counter saturates at 255: further pulses leave it at 255.
- R3: Before reading each entry, the consumer pointer advances by one modulo 256, so the read index is always the previous pointer plus one, wrapping from 255 to 0. Entries are consumed in ring order, and reading stops when the pointer equals the low 8 bits of `prod_wp`.
- R4: While `prod_wp` is 16'hFFFF, or while it equals the consumer pointer, no ring read is issued.
- R5: An entry with a valid address and bit 4 of the extended word set is offered on the event stream, with `evt_resp` equal to word 0 and `evt_ext` equal to word 1. It changes no pending counter and no stored response.
- R6: While an event is offered and not accepted, `evt_valid`, `evt_resp` and `evt_ext` hold steady, and no further ring read is issued.
- R7: A solicited entry (valid address, bit 4 clear) whose codec counter is non-zero stores word 0 into that codec's `codec_resp` slot and decrements the counter.
- R8: `codec_done[i]` pulses for one cycle exactly when an accepted response leaves codec i's counter at zero.
- R9: A solicited entry whose codec counter is zero is discarded and leaves all stored responses unchanged. `err_spurious` pulses for one cycle.
- R10: An entry whose address (bits 3:0 of word 1) is at least NUM_CODECS pulses `err_fatal` for one cycle and changes no state. This holds even when bit 4 is set.
- R11: `resp_irq` pulses for one cycle for every consumed entry: one cycle after the entry's dispatch edge, or one cycle after the event handshake for events. `err_spurious`, `err_fatal` and `codec_done` pulse only in that same cycle.
- R12: When an issue pulse and an acceptance hit the same codec at the same edge, the counter is unchanged and no completion fires. Acceptance is decided on the count before that edge's issue pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_wp | input | 16 | Producer write pointer; 16'hFFFF means powered down |
| ring_rd_en | output | 1 | Ring read strobe |
| ring_rd_idx | output | 8 | Ring slot being read |
| ring_rd_data | input | 64 | Entry for the slot read in the previous cycle; [31:0] response, [63:32] extended word |
| cmd_issue | input | NUM_CODECS | Per-codec command-issued pulse |
| codec_idle | output | NUM_CODECS | Pending counter is zero |
| codec_done | output | NUM_CODECS | Counter reached zero (pulse) |
| codec_resp | output | 32*NUM_CODECS | Last accepted response per codec, codec i at [32i+31:32i] |
| evt_valid | output | 1 | Event stream valid |
| evt_ready | input | 1 | Event stream ready |
| evt_resp | output | 32 | Event response word |
| evt_ext | output | 32 | Event extended word |
| resp_irq | output | 1 | One pulse per consumed entry |
| err_spurious | output | 1 | Solicited entry with no pending command (pulse) |
| err_fatal | output | 1 | Out-of-range codec address (pulse) |
| cons_rp | output | 8 | Consumer read pointer |

## Verification
The embedded assertions watch several properties on every clock:
- reads stay single and are never issued at power-down;
- pending counters never drop below zero and hold at saturation;
- completion and error pulses coincide with the per-entry interrupt and never both flag at once;
- a stalled event keeps its payload.

Only the bench scenarios can show the remaining behaviour. These cover the per-entry routing outcomes against a behavioural counter model, read ordering across the 255-to-0 wrap, saturation, and the issue/accept collision.

// File: rtl/resp_ring_pkg.sv
package resp_ring_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ADDR_W   = 4;   // codec address field width in word 1
  localparam int unsigned EVT_BIT  = 4;   // unsolicited marker position in word 1

  // word 1 (extended) sits in the upper half, word 0 (response) in the lower
  typedef struct packed {
    logic [WORD_W-1:0] ext;
    logic [WORD_W-1:0] resp;
  } ring_entry_t;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_FETCH,
    FS_WAIT,
    FS_DISP
  } fetch_state_e;

  typedef enum logic [1:0] {
    K_SOLICIT,
    K_EVENT,
    K_BADADDR
  } entry_kind_e;
endpackage

// File: rtl/resp_ring_fetch.sv
module resp_ring_fetch
  import resp_ring_pkg::*;
#(
  parameter  int unsigned RING_DEPTH = 256,   // power of two
  parameter  int unsigned WP_W       = 16,
  localparam int unsigned PTR_W      = $clog2(RING_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WP_W-1:0]  prod_wp,
  input  logic [63:0]      rd_data,
  input  logic             disp_done,
  output logic             rd_en,
  output logic [PTR_W-1:0] rd_idx,
  output logic [PTR_W-1:0] rp_o,
  output logic             ent_valid,
  output ring_entry_t      ent
);
  localparam logic [WP_W-1:0] WP_OFF = '1;

  fetch_state_e     st;
  logic [PTR_W-1:0] rp;
  logic [PTR_W-1:0] wp_snap;
  logic [PTR_W-1:0] wp_lo;
  logic             wp_live;
  logic             go;

  assign wp_lo   = prod_wp[PTR_W-1:0];
  assign wp_live = (prod_wp != WP_OFF);
  assign go      = wp_live && (wp_lo != rp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= FS_IDLE;
      rp      <= '0;
      wp_snap <= '0;
      ent     <= '0;
    end else begin
      unique case (st)
        FS_IDLE: begin
          if (go) begin
            wp_snap <= wp_lo;
            st      <= FS_FETCH;
          end
        end
        FS_FETCH: begin
          rp <= rp + 1'b1;
          st <= FS_WAIT;
        end
        FS_WAIT: begin
          ent <= ring_entry_t'(rd_data);
          st  <= FS_DISP;
        end
        FS_DISP: begin
          if (disp_done) st <= (rp == wp_snap) ? FS_IDLE : FS_FETCH;
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign rd_en     = (st == FS_FETCH);
  assign rd_idx    = rp + 1'b1;
  assign rp_o      = rp;
  assign ent_valid = (st == FS_DISP);

  // R4: a powered-down producer pointer never starts a read
  assert_no_read_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_IDLE && prod_wp == WP_OFF) |=> !rd_en);

  // R3: one entry in flight at a time
  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
endmodule

// File: rtl/resp_entry_decode.sv
module resp_entry_decode
  import resp_ring_pkg::*;
#(
  parameter int unsigned NUM_CODECS = 4
) (
  input  ring_entry_t           ent,
  output entry_kind_e           kind,
  output logic [NUM_CODECS-1:0] sel
);
  localparam logic [ADDR_W:0] ADDR_LIM = (ADDR_W+1)'(NUM_CODECS);

  logic [ADDR_W-1:0] addr;
  assign addr = ent.ext[ADDR_W-1:0];

  always_comb begin
    if ({1'b0, addr} >= ADDR_LIM)  kind = K_BADADDR;
    else if (ent.ext[EVT_BIT])     kind = K_EVENT;
    else                           kind = K_SOLICIT;
  end

  for (genvar g = 0; g < NUM_CODECS; g++) begin : g_sel
    assign sel[g] = (addr == ADDR_W'(g));
  end
endmodule

// File: rtl/codec_pend_slot.sv
module codec_pend_slot #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              accept,
  input  logic [DATA_W-1:0] resp_in,
  output logic              count_zero,
  output logic              done,
  output logic [DATA_W-1:0] resp_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      done   <= 1'b0;
      resp_q <= '0;
    end else begin
      if (accept && !issue)
        count <= count - 1'b1;
      else if (issue && !accept && count != CNT_MAX)
        count <= count + 1'b1;
      done <= accept && !issue && (count == CNT_W'(1));
      if (accept) resp_q <= resp_in;
    end
  end

  assign count_zero = (count == '0);

  // R2: saturation holds the counter at its ceiling
  assert_sat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && issue && !accept) |=> count == CNT_MAX);

  // R7: the dispatcher only accepts for a codec with outstanding commands
  assert_accept_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> count != '0);

  // R8: completion leaves the slot idle
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> count_zero);
endmodule

// File: rtl/resp_ring_dispatch.sv
module resp_ring_dispatch
  import resp_ring_pkg::*;
#(
  parameter  int unsigned NUM_CODECS = 4,
  parameter  int unsigned RING_DEPTH = 256,
  parameter  int unsigned CNT_W      = 8,
  parameter  int unsigned WP_W       = 16,
  localparam int unsigned PTR_W      = $clog2(RING_DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WP_W-1:0]              prod_wp,
  output logic                         ring_rd_en,
  output logic [PTR_W-1:0]             ring_rd_idx,
  input  logic [2*WORD_W-1:0]          ring_rd_data,
  input  logic [NUM_CODECS-1:0]        cmd_issue,
  output logic [NUM_CODECS-1:0]        codec_idle,
  output logic [NUM_CODECS-1:0]        codec_done,
  output logic [NUM_CODECS*WORD_W-1:0] codec_resp,
  output logic                         evt_valid,
  input  logic                         evt_ready,
  output logic [WORD_W-1:0]            evt_resp,
  output logic [WORD_W-1:0]            evt_ext,
  output logic                         resp_irq,
  output logic                         err_spurious,
  output logic                         err_fatal,
  output logic [PTR_W-1:0]             cons_rp
);
  ring_entry_t           ent;
  logic                  ent_valid;
  logic                  disp_done;
  entry_kind_e           kind;
  logic [NUM_CODECS-1:0] sel;
  logic [NUM_CODECS-1:0] accept;
  logic                  pend_hit;
  logic                  irq_q, spur_q, fatal_q;

  resp_ring_fetch #(
    .RING_DEPTH (RING_DEPTH),
    .WP_W       (WP_W)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .prod_wp   (prod_wp),
    .rd_data   (ring_rd_data),
    .disp_done (disp_done),
    .rd_en     (ring_rd_en),
    .rd_idx    (ring_rd_idx),
    .rp_o      (cons_rp),
    .ent_valid (ent_valid),
    .ent       (ent)
  );

  resp_entry_decode #(
    .NUM_CODECS (NUM_CODECS)
  ) u_decode (
    .ent  (ent),
    .kind (kind),
    .sel  (sel)
  );

  // an event waits for the stream; everything else retires in one cycle
  assign evt_valid = ent_valid && (kind == K_EVENT);
  assign evt_resp  = ent.resp;
  assign evt_ext   = ent.ext;
  assign disp_done = ent_valid && ((kind != K_EVENT) || evt_ready);
  assign pend_hit  = |(sel & ~codec_idle);

  for (genvar g = 0; g < NUM_CODECS; g++) begin : g_slot
    assign accept[g] = disp_done && (kind == K_SOLICIT) && sel[g] && !codec_idle[g];

    codec_pend_slot #(
      .CNT_W  (CNT_W),
      .DATA_W (WORD_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (cmd_issue[g]),
      .accept     (accept[g]),
      .resp_in    (ent.resp),
      .count_zero (codec_idle[g]),
      .done       (codec_done[g]),
      .resp_q     (codec_resp[g*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      spur_q  <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      irq_q   <= disp_done;
      spur_q  <= disp_done && (kind == K_SOLICIT) && !pend_hit;
      fatal_q <= disp_done && (kind == K_BADADDR);
    end
  end

  assign resp_irq     = irq_q;
  assign err_spurious = spur_q;
  assign err_fatal    = fatal_q;

  // R6: a stalled event keeps its payload
  assert_evt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_resp) && $stable(evt_ext)));

  // R11: error flags only accompany a consumed entry
  assert_err_with_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_spurious || err_fatal) |-> resp_irq);

  // R8: completion only accompanies a consumed entry
  assert_done_with_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|codec_done) |-> resp_irq);

  // R9: an entry is never both spurious and fatal
  assert_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_spurious, err_fatal}));
endmodule

// File: tb/test_resp_ring_dispatch.sv
module test_resp_ring_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] prod_wp = 16'h0;
  logic ring_rd_en;
  logic [7:0] ring_rd_idx;
  logic [63:0] ring_rd_data = '0;
  logic [NC-1:0] cmd_issue = '0;
  logic [NC-1:0] codec_idle, codec_done;
  logic [NC*32-1:0] codec_resp;
  logic evt_valid;
  logic evt_ready = 1'b1;
  logic [31:0] evt_resp, evt_ext;
  logic resp_irq, err_spurious, err_fatal;
  logic [7:0] cons_rp;

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_ring_dispatch i_resp_ring_dispatch (
    .clk(clk), .rst_n(rst_n), .prod_wp(prod_wp),
    .ring_rd_en(ring_rd_en), .ring_rd_idx(ring_rd_idx), .ring_rd_data(ring_rd_data),
    .cmd_issue(cmd_issue), .codec_idle(codec_idle), .codec_done(codec_done),
    .codec_resp(codec_resp), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_resp(evt_resp), .evt_ext(evt_ext), .resp_irq(resp_irq),
    .err_spurious(err_spurious), .err_fatal(err_fatal), .cons_rp(cons_rp)
  );

  // ring memory with one-cycle read latency
  logic [63:0] ring [256];
  always @(posedge clk) if (ring_rd_en) ring_rd_data <= ring[ring_rd_idx];

  int nchk = 0;
  int nfail = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural model state
  int          m_cnt [NC];
  logic [31:0] m_resp [NC];
  logic [63:0] m_q [$];
  int          m_rp = 0;
  int          bench_wp = 0;
  logic [NC-1:0] prev_cmd = '0;
  bit          model_on = 0;
  bit          hold_off = 0;

  initial for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_resp[i] = '0; end

  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
    if (model_on) begin
      logic [NC-1:0] exp_done;
      exp_done = '0;
      if (resp_irq) begin
        if (m_q.size() == 0) begin
          chk(0, "R11", "irq with no entry", 1, 0);
        end else begin
          logic [63:0] e;
          int a;
          bit f, ev, s, acc;
          e  = m_q.pop_front();
          a  = int'(e[35:32]);
          f  = (a >= NC);
          ev = !f && e[36];
          s  = !f && !ev && (m_cnt[a] == 0);
          acc = !f && !ev && (m_cnt[a] != 0);
          chk(err_fatal == f, "R10", "err_fatal", longint'(err_fatal), longint'(f));
          chk(err_spurious == s, "R9", "err_spurious", longint'(err_spurious), longint'(s));
          if (acc) begin
            m_cnt[a]--;
            m_resp[a] = e[31:0];
          end
          for (int i = 0; i < NC; i++)
            if (prev_cmd[i] && m_cnt[i] < 255) m_cnt[i]++;
          if (acc && m_cnt[a] == 0) exp_done[a] = 1'b1;
          chk(codec_done == exp_done, "R8/R12", "codec_done", longint'(codec_done), longint'(exp_done));
        end
      end else begin
        for (int i = 0; i < NC; i++)
          if (prev_cmd[i] && m_cnt[i] < 255) m_cnt[i]++;
        chk(!err_spurious && !err_fatal && codec_done == '0, "R11", "flags without irq",
            longint'({err_spurious, err_fatal, codec_done}), 0);
      end
      prev_cmd = cmd_issue;
      // R2 R7: per-codec idle and stored responses every clock
      for (int i = 0; i < NC; i++) begin
        chk(codec_idle[i] == (m_cnt[i] == 0), "R2/R7", "codec_idle",
            longint'(codec_idle[i]), longint'(m_cnt[i] == 0));
        chk(codec_resp[i*32 +: 32] == m_resp[i], "R7/R9", "codec_resp",
            longint'(codec_resp[i*32 +: 32]), longint'(m_resp[i]));
      end
      // R3: read index ordering with wrap
      if (ring_rd_en) begin
        chk(!hold_off, "R4", "read while held off", 1, 0);
        m_rp = (m_rp + 1) % 256;
        chk(ring_rd_idx == 8'(m_rp), "R3", "ring_rd_idx", longint'(ring_rd_idx), longint'(m_rp));
      end
      // R5: offered event matches the oldest unconsumed entry
      if (evt_valid) begin
        if (m_q.size() == 0) chk(0, "R5", "event with empty model", 1, 0);
        else chk({evt_ext, evt_resp} == m_q[0] && m_q[0][36], "R5", "event payload",
                 longint'({evt_ext, evt_resp}), longint'(m_q[0]));
      end
    end
  end

  task automatic drv();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [31:0] r, input logic [3:0] addr, input bit ev);
    bench_wp = (bench_wp + 1) % 256;
    ring[bench_wp] = {27'h0, ev, addr, r};
    m_q.push_back({27'h0, ev, addr, r});
  endtask

  task automatic publish();
    drv();
    prod_wp = 16'(bench_wp);
  endtask

  task automatic drain();
    while (m_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic issue(input int c, input int n);
    drv();
    cmd_issue[c] = 1'b1;
    repeat (n - 1) drv();
    drv();
    cmd_issue[c] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ring[i] = '0;
    repeat (3) drv();
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(codec_idle == '1, "R1", "codec_idle", longint'(codec_idle), 15);
    chk(cons_rp == 8'h0, "R1", "cons_rp", longint'(cons_rp), 0);
    chk(!ring_rd_en && !evt_valid && !resp_irq && !err_spurious && !err_fatal && codec_done == '0,
        "R1", "outputs idle", longint'({ring_rd_en, evt_valid, resp_irq, err_spurious, err_fatal}), 0);
    model_on = 1;

    // R4: unchanged pointer gives no reads
    hold_off = 1;
    repeat (10) @(negedge clk);
    hold_off = 0;

    // R2 R5 R7 R8: mixed routing
    issue(1, 2);
    issue(2, 1);
    push(32'hA1A1_0001, 4'd1, 0);
    push(32'hE0E0_0002, 4'd2, 1);
    push(32'hB2B2_0003, 4'd2, 0);
    push(32'hC1C1_0004, 4'd1, 0);
    publish();
    drain();
    chk(codec_idle == '1, "R8", "all idle after mixed", longint'(codec_idle), 15);

    // R9: spurious for codec 3, R10: bad addresses with and without event bit
    push(32'h5555_0005, 4'd3, 0);
    push(32'hDEAD_0006, 4'd5, 1);
    push(32'hDEAD_0007, 4'd15, 0);
    publish();
    drain();

    // R4: powered-down pointer leaves new entries untouched
    push(32'h7777_0008, 4'd0, 1);
    drv();
    prod_wp = 16'hFFFF;
    hold_off = 1;
    repeat (12) @(negedge clk);
    chk(m_q.size() == 1, "R4", "entries left while off", longint'(m_q.size()), 1);
    hold_off = 0;
    publish();
    drain();

    // R6: event back-pressure stalls the ring
    drv();
    evt_ready = 1'b0;
    issue(0, 1);
    push(32'h9999_0009, 4'd0, 1);
    push(32'h8888_000A, 4'd0, 0);
    publish();
    while (!evt_valid) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(evt_valid && !ring_rd_en, "R6", "stall holds", longint'({evt_valid, ring_rd_en}), 2);
    end
    drv();
    evt_ready = 1'b1;
    drain();

    // R12: issue collides with acceptance (count 1 -> stays 1, no done)
    issue(0, 1);
    push(32'h1212_000B, 4'd0, 0);
    publish();
    drv(); drv(); drv();
    cmd_issue[0] = 1'b1;
    drv();
    cmd_issue[0] = 1'b0;
    drain();
    chk(codec_idle[0] == 1'b0, "R12", "count kept after collision", longint'(codec_idle[0]), 0);
    push(32'h1313_000C, 4'd0, 0);
    publish();
    drain();
    // R12: issue collides with a zero count -> spurious, count becomes 1
    push(32'h1414_000D, 4'd0, 0);
    publish();
    drv(); drv(); drv();
    cmd_issue[0] = 1'b1;
    drv();
    cmd_issue[0] = 1'b0;
    drain();
    chk(codec_idle[0] == 1'b0, "R12", "issue after spurious", longint'(codec_idle[0]), 0);
    push(32'h1515_000E, 4'd0, 0);
    publish();
    drain();

    // R2 R3: saturation at 255 and pointer wrap
    issue(3, 300);
    for (int k = 0; k < 200; k++) push(32'h3000_0000 + k, 4'd3, 0);
    publish();
    drain();
    for (int k = 200; k < 256; k++) push(32'h3000_0000 + k, 4'd3, 0);
    publish();
    drain();
    chk(codec_resp[3*32 +: 32] == 32'h3000_00FE, "R2", "last accepted after saturation",
        longint'(codec_resp[3*32 +: 32]), 32'h3000_00FE);
    chk(cons_rp == 8'(bench_wp), "R3", "pointer caught up", longint'(cons_rp), longint'(bench_wp));

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule